// File: doc/BRIEF.md
# Synchronous Slave Serial Receiver

This block receives serial words whose shift clock comes from an external master. The block never drives that clock. It resynchronises the incoming clock and the data line into the system clock domain. On every rising edge of the resynchronised shift clock it takes one data bit, least significant bit first. When 8 bits have arrived, or 9 when the wide format is selected, it moves the whole word into a holding register for the host to read.

A receive-enable input gates the whole path. While it is high, the block collects bits, raises a word-ready flag and, when the host allows it, an interrupt request. A host read strobe clears the word-ready flag. A word can finish while the previous one is still unread. In that case the block drops the new word, sets a sticky overrun flag and freezes reception. Lowering the receive enable is the only way to clear that state.

Top module: `ssr_slave_rx`

## Requirements
- R1: `sclk_in` and `sdata_in` each pass through two system-clock flops. A rising edge of the synchronised shift clock takes the synchronised data bit. When that rise completes a word, `rx_data`, `rx_bit8`, `rx_full`, `overrun` and `irq` change at the third `clk` rising edge after `sclk_in` rises. Each `sclk_in` phase must last at least three `clk` cycles.
- R2: Bits are assembled least significant bit first. In 8-bit format (`nine_sel`=0) the k-th sampled bit of a word becomes bit k of `rx_data`, for k from 0 to 7.
- R3: With `nine_sel`=1 a word is 9 bits long. The first 8 bits fill `rx_data` and the ninth bit goes to `rx_bit8`. A word completed in 8-bit format loads 0 into `rx_bit8`.
- R4: When a word completes and `rx_full` is clear, the word is loaded into `rx_data`/`rx_bit8` and `rx_full` is set on that same edge.
- R5: `irq` is high exactly when `rx_full` and `rx_ie` are both high.
- R6: A one-cycle `rd_strobe` clears `rx_full` at that edge. If a word completes on the same edge, the load wins and `rx_full` stays set.
- R7: A word that completes while `rx_full` is set, with no `rd_strobe` on that edge, sets `overrun` and is discarded. `rx_data` and `rx_bit8` keep their values. Later shift clock edges assemble nothing until `overrun` is cleared.
- R8: While `cont_en` is low, shift clock edges are ignored, the bit count and the partial word are cleared, and `overrun` is cleared at the next edge. `rx_data` and `rx_full` keep their values.
- R9: After a synchronous reset `rx_data`, `rx_bit8`, `rx_full`, `overrun` and `irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_in | input | 1 | Shift clock from the external master, asynchronous to `clk` |
| sdata_in | input | 1 | Serial data line |
| cont_en | input | 1 | Continuous receive enable; low clears errors and the partial word |
| nine_sel | input | 1 | 1 selects 9-bit words |
| rx_ie | input | 1 | Receive interrupt enable |
| rd_strobe | input | 1 | One-cycle host read of the holding register |
| rx_data | output | DATA_W | Received word, low bits |
| rx_bit8 | output | 1 | Received ninth bit |
| rx_full | output | 1 | Word-ready flag |
| overrun | output | 1 | Sticky overrun error |
| irq | output | 1 | Receive interrupt request |

## Verification
A bit counter left wrong by one position shows up at the ports on the first completed word. The data then appears shifted, or it lands a shift edge early or late, and the full flag appears in the wrong cycle relative to the last shift clock rise. A stale partial word left behind after the enable drops shows up in the first word received afterwards. A wrong overrun state shows up as changed held data or a frozen receiver, and the first word that completes after the fault reveals it. The bench compares every output against its model on every clock, so any of these faults is reported within one cycle of becoming visible.

// File: rtl/ssr_pkg.sv
package ssr_pkg;

    typedef enum logic {
        FMT_BYTE = 1'b0,
        FMT_NINE = 1'b1
    } fmt_e;

    typedef struct packed {
        logic full;
        logic ovr;
    } rx_flags_t;

    // Index of the final bit of a word for the selected format.
    function automatic int unsigned last_index(fmt_e fmt, int unsigned data_w);
        return (fmt == FMT_NINE) ? data_w : data_w - 1;
    endfunction

endpackage

// File: rtl/ssr_sync.sv
module ssr_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sclk_async,
    input  logic sdat_async,
    output logic rise,
    output logic sbit
);

    logic [STAGES-1:0] ck_chain;
    logic [STAGES-1:0] dt_chain;
    logic              ck_prev;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) begin
                    ck_chain[i] <= 1'b0;
                    dt_chain[i] <= 1'b0;
                end else begin
                    ck_chain[i] <= sclk_async;
                    dt_chain[i] <= sdat_async;
                end
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) begin
                    ck_chain[i] <= 1'b0;
                    dt_chain[i] <= 1'b0;
                end else begin
                    ck_chain[i] <= ck_chain[i-1];
                    dt_chain[i] <= dt_chain[i-1];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ck_prev <= 1'b0;
        else     ck_prev <= ck_chain[STAGES-1];
    end

    assign rise = ck_chain[STAGES-1] & ~ck_prev;
    assign sbit = dt_chain[STAGES-1];

    // R1: an edge of the shift clock yields a single one-cycle sample pulse
    p_rise_pulse_r1: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);

endmodule

// File: rtl/ssr_shift.sv
module ssr_shift
    import ssr_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            run,
    input  logic            hold,
    input  fmt_e            fmt,
    input  logic            rise,
    input  logic            sbit,
    output logic            word_done,
    output logic [DATA_W:0] word
);

    localparam int unsigned CNT_W = $clog2(DATA_W + 1);

    logic [CNT_W-1:0] cnt;
    logic [DATA_W:0]  shreg;
    logic [DATA_W:0]  next_word;
    logic             at_last;

    assign at_last = (32'(cnt) == last_index(fmt, DATA_W));

    always_comb begin
        next_word      = shreg;
        next_word[cnt] = sbit;
    end

    assign word_done = run & ~hold & rise & at_last;
    assign word      = next_word;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt   <= '0;
            shreg <= '0;
        end else if (rise && !hold) begin
            if (at_last) begin
                cnt   <= '0;
                shreg <= '0;
            end else begin
                cnt   <= cnt + 1'b1;
                shreg <= next_word;
            end
        end
    end

    // R2: the bit index never passes the widest word
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (rst)
        32'(cnt) <= DATA_W);

    // R8: a dropped enable leaves no partial word behind
    p_drop_clears_cnt_r8: assert property (@(posedge clk) disable iff (rst)
        !run |=> (cnt == '0 && shreg == '0));

    // R7: while frozen, shift edges do not move the bit index
    p_hold_freezes_r7: assert property (@(posedge clk) disable iff (rst)
        (run && hold) |=> $stable(cnt));

endmodule

// File: rtl/ssr_hold.sv
module ssr_hold
    import ssr_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              rd,
    input  fmt_e              fmt,
    input  logic              word_done,
    input  logic [DATA_W:0]   word,
    output logic [DATA_W-1:0] data,
    output logic              bit8,
    output rx_flags_t         flags
);

    always_ff @(posedge clk) begin
        if (rst) begin
            data  <= '0;
            bit8  <= 1'b0;
            flags <= '{full: 1'b0, ovr: 1'b0};
        end else begin
            if (!run) flags.ovr <= 1'b0;
            if (word_done) begin
                if (flags.full && !rd) begin
                    flags.ovr <= 1'b1;
                end else begin
                    data       <= word[DATA_W-1:0];
                    bit8       <= (fmt == FMT_NINE) ? word[DATA_W] : 1'b0;
                    flags.full <= 1'b1;
                end
            end else if (rd) begin
                flags.full <= 1'b0;
            end
        end
    end

    // R4: a completed word always leaves the ready flag set
    p_load_sets_full_r4: assert property (@(posedge clk) disable iff (rst)
        word_done |=> flags.full);

    // R6: a read with no competing load empties the register
    p_read_clears_r6: assert property (@(posedge clk) disable iff (rst)
        (rd && !word_done) |=> !flags.full);

    // R7: held data is untouched while the overrun state persists
    p_overrun_keeps_r7: assert property (@(posedge clk) disable iff (rst)
        (flags.ovr && run) |=> ($stable(data) && $stable(bit8)));

    // R8: dropping the enable clears the error
    p_drop_clears_ovr_r8: assert property (@(posedge clk) disable iff (rst)
        !run |=> !flags.ovr);

endmodule

// File: rtl/ssr_slave_rx.sv
module ssr_slave_rx
    import ssr_pkg::*;
#(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_in,
    input  logic              sdata_in,
    input  logic              cont_en,
    input  logic              nine_sel,
    input  logic              rx_ie,
    input  logic              rd_strobe,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_bit8,
    output logic              rx_full,
    output logic              overrun,
    output logic              irq
);

    logic            rise;
    logic            sbit;
    logic            word_done;
    logic [DATA_W:0] word;
    rx_flags_t       flags;
    fmt_e            fmt;

    assign fmt = nine_sel ? FMT_NINE : FMT_BYTE;

    ssr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst        (rst),
        .sclk_async (sclk_in),
        .sdat_async (sdata_in),
        .rise       (rise),
        .sbit       (sbit)
    );

    ssr_shift #(.DATA_W(DATA_W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .run       (cont_en),
        .hold      (flags.ovr),
        .fmt       (fmt),
        .rise      (rise),
        .sbit      (sbit),
        .word_done (word_done),
        .word      (word)
    );

    ssr_hold #(.DATA_W(DATA_W)) u_hold (
        .clk       (clk),
        .rst       (rst),
        .run       (cont_en),
        .rd        (rd_strobe),
        .fmt       (fmt),
        .word_done (word_done),
        .word      (word),
        .data      (rx_data),
        .bit8      (rx_bit8),
        .flags     (flags)
    );

    assign rx_full = flags.full;
    assign overrun = flags.ovr;
    assign irq     = flags.full & rx_ie;

    // R7: no word completes while the receiver is frozen by an overrun
    p_no_load_in_ovr_r7: assert property (@(posedge clk) disable iff (rst)
        overrun |-> !word_done);

endmodule

// File: tb/ssr_slave_rx_bench.sv
module ssr_slave_rx_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sclk_in = 1'b0;
    logic       sdata_in = 1'b0;
    logic       cont_en = 1'b0;
    logic       nine_sel = 1'b0;
    logic       rx_ie = 1'b0;
    logic       rd_strobe = 1'b0;
    logic [7:0] rx_data;
    logic       rx_bit8;
    logic       rx_full;
    logic       overrun;
    logic       irq;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit started  = 1'b0;

    always #4 clk = ~clk;

    ssr_slave_rx u_ssr_slave_rx (
        .clk(clk), .rst(rst), .sclk_in(sclk_in), .sdata_in(sdata_in),
        .cont_en(cont_en), .nine_sel(nine_sel), .rx_ie(rx_ie),
        .rd_strobe(rd_strobe), .rx_data(rx_data), .rx_bit8(rx_bit8),
        .rx_full(rx_full), .overrun(overrun), .irq(irq)
    );

    // Behavioural reference model
    bit ck_hist[$];
    bit dt_hist[$];
    int m_cnt, m_word, m_data;
    bit m_b8, m_full, m_ovr;

    always @(posedge clk) begin
        bit rs, b, done;
        if (rst) begin
            ck_hist = '{0, 0, 0};
            dt_hist = '{0, 0, 0};
            m_cnt = 0; m_word = 0; m_data = 0;
            m_b8 = 0; m_full = 0; m_ovr = 0;
        end else begin
            rs = ck_hist[1] && !ck_hist[2];
            b  = dt_hist[1];
            done = 0;
            if (!cont_en) begin
                m_cnt = 0; m_word = 0; m_ovr = 0;
            end else if (!m_ovr && rs) begin
                if (b) m_word = m_word + (1 << m_cnt);
                if (m_cnt == (nine_sel ? 8 : 7)) done = 1;
                else m_cnt++;
            end
            if (done) begin
                if (m_full && !rd_strobe) m_ovr = 1;
                else begin
                    m_data = m_word % 256;
                    m_b8   = nine_sel ? m_word[8] : 1'b0;
                    m_full = 1;
                end
                m_cnt = 0; m_word = 0;
            end else if (rd_strobe) begin
                m_full = 0;
            end
            void'(ck_hist.pop_back()); ck_hist.push_front(sclk_in);
            void'(dt_hist.pop_back()); dt_hist.push_front(sdata_in);
        end
        started = 1'b1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (started) begin
            check(int'(rx_data) == m_data, "R2 rx_data", int'(rx_data), m_data);
            check(rx_bit8 == m_b8, "R3 rx_bit8", int'(rx_bit8), int'(m_b8));
            check(rx_full == m_full, "R4 rx_full", int'(rx_full), int'(m_full));
            check(overrun == m_ovr, "R7 overrun", int'(overrun), int'(m_ovr));
            check(irq == (m_full && rx_ie), "R5 irq", int'(irq), int'(m_full && rx_ie));
        end
    end

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic send_bit(input bit b);
        @(negedge clk);
        sclk_in = 1'b0; sdata_in = b;
        wait_n(4);
        sclk_in = 1'b1;
        wait_n(4);
    endtask

    task automatic send_word(input int val, input int nbits);
        for (int i = 0; i < nbits; i++) send_bit(val[i]);
    endtask

    task automatic host_read();
        @(negedge clk); rd_strobe = 1'b1;
        @(negedge clk); rd_strobe = 1'b0;
    endtask

    initial begin
        while (cycles < 150000) begin
            @(posedge clk); cycles++;
        end
        check(1'b0, "watchdog", cycles, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        wait_n(3);
        rst = 1'b0;
        @(negedge clk);
        // R9: reset state
        check(rx_data == 8'h00 && !rx_bit8 && !rx_full && !overrun && !irq,
              "R9 reset state", {rx_data, rx_bit8, rx_full, overrun, irq}, 0);

        // R8: edges with the enable low are ignored
        send_word(8'h5A, 8);
        check(!rx_full, "R8 disabled ignores", int'(rx_full), 0);

        // R1/R2/R4/R5: 8-bit word with latency check on the last bit
        cont_en = 1'b1; rx_ie = 1'b1;
        send_word(8'h25, 7);
        @(negedge clk); sclk_in = 1'b0; sdata_in = 1'b1;
        wait_n(4);
        sclk_in = 1'b1;
        wait_n(2);
        check(!rx_full, "R1 not before third edge", int'(rx_full), 0);
        wait_n(1);
        check(rx_full, "R1 third edge", int'(rx_full), 1);
        check(rx_data == 8'hA5, "R2 lsb first", int'(rx_data), 'hA5);
        check(irq, "R5 irq with enable", int'(irq), 1);

        // R6: read clears the flag
        host_read();
        check(!rx_full, "R6 read clears", int'(rx_full), 0);

        // R3: nine-bit word then byte word
        nine_sel = 1'b1;
        send_word(9'h13C, 9);
        check(rx_data == 8'h3C && rx_bit8, "R3 nine bit", {rx_data, rx_bit8}, 'h79);
        host_read();
        nine_sel = 1'b0;
        send_word(8'hC3, 8);
        check(rx_data == 8'hC3 && !rx_bit8, "R3 byte clears bit8", {rx_data, rx_bit8}, 'h186);

        // R5: no irq without enable
        rx_ie = 1'b0;
        @(negedge clk);
        check(rx_full && !irq, "R5 irq masked", {rx_full, irq}, 2);

        // R7: second unread word causes overrun and is dropped
        send_word(8'h81, 8);
        check(overrun && rx_data == 8'hC3, "R7 overrun keeps data", {overrun, rx_data}, 'h1C3);
        host_read();
        send_word(8'h7E, 8);
        check(!rx_full && rx_data == 8'hC3, "R7 frozen after overrun", {rx_full, rx_data}, 'hC3);

        // R8: drop the enable clears overrun and the partial word
        @(negedge clk); cont_en = 1'b0;
        wait_n(2);
        check(!overrun, "R8 overrun cleared", int'(overrun), 0);
        cont_en = 1'b1;
        send_word(8'h07, 3);
        @(negedge clk); cont_en = 1'b0;
        wait_n(2);
        cont_en = 1'b1;
        send_word(8'h96, 8);
        check(rx_full && rx_data == 8'h96, "R8 partial discarded", {rx_full, rx_data}, 'h196);
        host_read();

        wait_n(5);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule